// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped Data Cache

This block is a small fully associative store that sits next to a direct-mapped data cache (4 KB in the intended use) and keeps blocks the cache has recently thrown out. The cache consults it only after its own lookup has missed. The request carries the block address being sought and, in the same cycle, the line that currently occupies the conflicting cache slot: its address, data and valid flag.

All entries are compared against the requested address at once. On a match the stored block is handed back so the cache can install it, and the displaced cache line is written into the same entry. The two blocks thereby trade places. On no match the displaced line, if valid, is kept. It goes into a free entry when one exists and otherwise replaces the entry whose contents were written longest ago. The answer (hit flag and block data) appears on the cycle after the request. Memory refill, the cache arrays and write-back of dirty data belong to the surrounding cache.

Top module: `victimCache`

## Requirements
- R1: After reset every entry is empty and `rspValid` is low; the first lookup after reset misses.
- R2: A request with `lookupValid` high in cycle n gives `rspValid` high in cycle n+1, with `rspHit` and `rspData` valid in that cycle; with no request `rspValid` is low.
- R3: A lookup hits only when an entry is valid and its stored full block address equals `lookupAddr`; `rspData` is then that entry's stored block.
- R4: On a hit, the matching entry is overwritten by the displaced block (`evictAddr`, `evictData`); the hit block is no longer found afterwards and all other entries are unchanged.
- R5: On a hit with `evictValid` low, the matching entry becomes empty.
- R6: On a miss with `evictValid` high, the displaced block is written into the lowest-numbered empty entry when any entry is empty.
- R7: On a miss with `evictValid` high and all entries full, the displaced block replaces the entry written least recently; a swap into an entry counts as a write to it.
- R8: On a miss with `evictValid` low, the store is left unchanged.
- R9: While `lookupValid` is low, the evict inputs have no effect on the store.
- R10: On a miss `rspData` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Request: the main cache missed this cycle |
| lookupAddr | input | ADDR_W | Block address that missed |
| evictValid | input | 1 | The displaced cache line is valid |
| evictAddr | input | ADDR_W | Block address of the displaced line |
| evictData | input | DATA_W | Data of the displaced line |
| rspValid | output | 1 | Response present (one cycle after request) |
| rspHit | output | 1 | Victim entry matched |
| rspData | output | DATA_W | Matched block data, zero on miss |

## Verification
The bench builds the block with four entries, a 6-bit block address and 16-bit block data, so a small pool of twelve addresses spread over a four-line model cache keeps every entry busy and forces swaps, fills of empty entries and oldest-entry replacement within a few hundred requests. The narrow widths also let a model cache line be dropped at random, which puts requests carrying an invalid displaced line through both the hit and the miss path. Directed sequences pin down the ordering cases: the free-entry priority, replacement order after an entry has been emptied, and idle cycles with junk on the evict inputs.

// File: rtl/vcPkg.sv
package vcPkg;

  // Strobes from control to datapath, one request per cycle
  typedef struct packed {
    logic wrEn;     // write the selected entry this cycle
    logic wrValid;  // value of the valid bit written
    logic capture;  // register a response
    logic hit;      // the current lookup matched
  } vcStrobe_t;

endpackage

// File: rtl/vcStore.sv
module vcStore #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 27,
  parameter int DATA_W  = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   lookupAddr,
  input  logic [ADDR_W-1:0]   evictAddr,
  input  logic [DATA_W-1:0]   evictData,
  input  vcPkg::vcStrobe_t    strb,
  input  logic [ENTRIES-1:0]  wrSel,
  output logic [ENTRIES-1:0]  matchVec,
  output logic [ENTRIES-1:0]  validVec,
  output logic [DATA_W-1:0]   rspData
);

  logic [ADDR_W-1:0] tagQ  [ENTRIES];
  logic [DATA_W-1:0] dataQ [ENTRIES];
  logic [DATA_W-1:0] readData;

  for (genvar i = 0; i < ENTRIES; i++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        validVec[i] <= 1'b0;
        tagQ[i]     <= '0;
        dataQ[i]    <= '0;
      end else if (strb.wrEn && wrSel[i]) begin
        validVec[i] <= strb.wrValid;
        if (strb.wrValid) begin
          tagQ[i]  <= evictAddr;
          dataQ[i] <= evictData;
        end
      end
    end

    assign matchVec[i] = validVec[i] && (tagQ[i] == lookupAddr);

    // R4 / R9: an entry not selected for writing keeps its contents
    p_unselected_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.wrEn && wrSel[i]) |=> ($stable(validVec[i]) && $stable(tagQ[i]) && $stable(dataQ[i])));
  end

  // AND-OR read mux, at most one entry matches
  always_comb begin
    readData = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (matchVec[k]) readData = readData | dataQ[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspData <= '0;
    end else if (strb.capture) begin
      rspData <= strb.hit ? readData : '0;
    end
  end

endmodule

// File: rtl/vcCtrl.sv
module vcCtrl #(
  parameter int ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic               evictValid,
  input  logic [ENTRIES-1:0] matchVec,
  input  logic [ENTRIES-1:0] validVec,
  output vcPkg::vcStrobe_t   strb,
  output logic [ENTRIES-1:0] wrSel,
  output logic               rspValid,
  output logic               rspHit
);

  localparam logic [ENTRIES-1:0] ONE = {{(ENTRIES-1){1'b0}}, 1'b1};

  // olderQ[i][j] set: entry i was written before entry j
  logic [ENTRIES-1:0] olderQ [ENTRIES];
  logic [ENTRIES-1:0] oldestVec;
  logic [ENTRIES-1:0] firstFree;
  logic               anyFree;
  logic               hitNow;

  for (genvar i = 0; i < ENTRIES; i++) begin : gOldest
    assign oldestVec[i] = &(olderQ[i] | (ONE << i));
  end

  always_comb begin
    firstFree = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (!validVec[k]) begin
        firstFree    = '0;
        firstFree[k] = 1'b1;
      end
    end
  end

  assign anyFree = ~&validVec;
  assign hitNow  = lookupValid && (|matchVec);

  always_comb begin
    if (hitNow)       wrSel = matchVec;
    else if (anyFree) wrSel = firstFree;
    else              wrSel = oldestVec;
  end

  always_comb begin
    strb.wrEn    = lookupValid && (hitNow || evictValid);
    strb.wrValid = evictValid;
    strb.capture = lookupValid;
    strb.hit     = hitNow;
  end

  // Insertion order, updated whenever a valid block is written
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        for (int j = 0; j < ENTRIES; j++) begin
          olderQ[i][j] <= (i < j);
        end
      end
    end else if (strb.wrEn && strb.wrValid) begin
      for (int i = 0; i < ENTRIES; i++) begin
        for (int j = 0; j < ENTRIES; j++) begin
          if (i != j) begin
            if (wrSel[i])      olderQ[i][j] <= 1'b0;
            else if (wrSel[j]) olderQ[i][j] <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
    end else begin
      rspValid <= lookupValid;
      rspHit   <= hitNow;
    end
  end

  // R2: a response follows each request, and only a request
  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> rspValid);
  p_no_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !rspValid);
  // R3: full-address tags never match twice
  p_single_match_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));
  // R4: every write targets exactly one entry
  p_write_one_entry_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> ($countones(wrSel) == 1));
  // R6: a miss fills an empty entry while one exists
  p_fill_free_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && !hitNow && anyFree) |-> ((wrSel & validVec) == '0));
  // R7: insertion order always names exactly one oldest entry
  p_oldest_unique_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(oldestVec));
  // R8: a miss with nothing to keep leaves the valid bits alone
  p_miss_no_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && !hitNow && !evictValid) |=> $stable(validVec));
  // R9: no request, no write
  p_idle_no_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> !strb.wrEn);

endmodule

// File: rtl/victimCache.sv
module victimCache #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 27,
  parameter int DATA_W  = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic              evictValid,
  input  logic [ADDR_W-1:0] evictAddr,
  input  logic [DATA_W-1:0] evictData,
  output logic              rspValid,
  output logic              rspHit,
  output logic [DATA_W-1:0] rspData
);

  vcPkg::vcStrobe_t   strb;
  logic [ENTRIES-1:0] wrSel;
  logic [ENTRIES-1:0] matchVec;
  logic [ENTRIES-1:0] validVec;

  vcCtrl #(.ENTRIES(ENTRIES)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .lookupValid (lookupValid),
    .evictValid  (evictValid),
    .matchVec    (matchVec),
    .validVec    (validVec),
    .strb        (strb),
    .wrSel       (wrSel),
    .rspValid    (rspValid),
    .rspHit      (rspHit)
  );

  vcStore #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uStore (
    .clk        (clk),
    .rstN       (rstN),
    .lookupAddr (lookupAddr),
    .evictAddr  (evictAddr),
    .evictData  (evictData),
    .strb       (strb),
    .wrSel      (wrSel),
    .matchVec   (matchVec),
    .validVec   (validVec),
    .rspData    (rspData)
  );

  // R10: a miss returns all-zero data
  p_miss_data_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspData == '0));

endmodule

// File: tb/tb_victimCache.sv
module tb_victimCache;

  localparam int N  = 4;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int LINES = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lookupValid = 1'b0;
  logic [AW-1:0] lookupAddr = '0;
  logic          evictValid = 1'b0;
  logic [AW-1:0] evictAddr = '0;
  logic [DW-1:0] evictData = '0;
  logic          rspValid;
  logic          rspHit;
  logic [DW-1:0] rspData;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  victimCache #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .evictValid(evictValid), .evictAddr(evictAddr), .evictData(evictData),
    .rspValid(rspValid), .rspHit(rspHit), .rspData(rspData)
  );

  always #5 clk = ~clk;

  // Reference store model
  bit            mV [N];
  logic [AW-1:0] mA [N];
  logic [DW-1:0] mD [N];
  int            mStamp [N];
  int            stampCnt;

  // Model main cache
  bit            cV [LINES];
  logic [AW-1:0] cA [LINES];

  function automatic logic [DW-1:0] hashData(input logic [AW-1:0] a);
    return DW'((32'(a) + 1) * 32'h9e37);
  endfunction

  function automatic void modelClear();
    for (int i = 0; i < N; i++) begin
      mV[i] = 1'b0; mA[i] = '0; mD[i] = '0; mStamp[i] = 0;
    end
    stampCnt = 0;
  endfunction

  function automatic void modelAccess(input logic [AW-1:0] a, input bit evV,
      input logic [AW-1:0] evA, input logic [DW-1:0] evD,
      output bit expHit, output logic [DW-1:0] expData);
    int slot;
    slot = -1;
    for (int i = 0; i < N; i++) if (mV[i] && mA[i] == a) slot = i;
    expHit  = (slot >= 0);
    expData = '0;
    if (expHit) begin
      expData = mD[slot];
      if (evV) begin
        mA[slot] = evA; mD[slot] = evD; stampCnt++; mStamp[slot] = stampCnt;
      end else begin
        mV[slot] = 1'b0;
      end
    end else if (evV) begin
      for (int i = N - 1; i >= 0; i--) if (!mV[i]) slot = i;
      if (slot < 0) begin
        slot = 0;
        for (int i = 1; i < N; i++) if (mStamp[i] < mStamp[slot]) slot = i;
      end
      mV[slot] = 1'b1; mA[slot] = evA; mD[slot] = evD;
      stampCnt++; mStamp[slot] = stampCnt;
    end
  endfunction

  task automatic check(input bit ok, input string msg);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s", msg);
    end
  endtask

  // Called at a negedge; returns at the negedge after the response edge
  task automatic doLookup(input logic [AW-1:0] a, input bit evV,
      input logic [AW-1:0] evA, input string tag);
    bit expHit;
    logic [DW-1:0] expData;
    lookupValid = 1'b1;
    lookupAddr  = a;
    evictValid  = evV;
    evictAddr   = evA;
    evictData   = hashData(evA);
    modelAccess(a, evV, evA, hashData(evA), expHit, expData);
    @(negedge clk);
    check(rspValid === 1'b1 && rspHit === expHit && rspData === expData,
      $sformatf("%s (R2 response) addr=%0d valid=%0b hit=%0b data=%h expected valid=1 hit=%0b data=%h",
        tag, a, rspValid, rspHit, rspData, expHit, expData));
    lookupValid = 1'b0;
  endtask

  // R9: idle cycle with junk on the evict inputs
  task automatic idleJunk();
    lookupValid = 1'b0;
    lookupAddr  = AW'($urandom);
    evictValid  = 1'($urandom);
    evictAddr   = AW'($urandom);
    evictData   = DW'($urandom);
    @(negedge clk);
    check(rspValid === 1'b0,
      $sformatf("R9 idle rspValid=%0b expected 0", rspValid));
  endtask

  task automatic applyReset();
    rstN = 1'b0;
    lookupValid = 1'b0;
    repeat (3) @(negedge clk);
    check(rspValid === 1'b0 && rspData === '0,
      $sformatf("R1 reset rspValid=%0b rspData=%h expected 0/0", rspValid, rspData));
    rstN = 1'b1;
    modelClear();
    for (int l = 0; l < LINES; l++) begin cV[l] = 1'b0; cA[l] = '0; end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h1234_5678);
    @(negedge clk);
    applyReset();

    // R1: first lookup misses, nothing kept; R10 zero data
    doLookup(6'd50, 1'b0, 6'd0, "R1");
    doLookup(6'd51, 1'b0, 6'd0, "R10");

    // R6: fill entries 0..3 with blocks 1..4
    for (int k = 1; k <= 4; k++) doLookup(6'(40 + k), 1'b1, 6'(k), "R6");

    // R3 hit on block 1, swap in block 5 (R4)
    doLookup(6'd1, 1'b1, 6'd5, "R3");
    doLookup(6'd1, 1'b0, 6'd0, "R4");
    // R5: hit block 5 with invalid displaced line empties the entry
    doLookup(6'd5, 1'b0, 6'd0, "R4");
    doLookup(6'd5, 1'b0, 6'd0, "R5");

    // R6: the emptied entry is reused
    doLookup(6'd44, 1'b1, 6'd6, "R6");
    // R7: full now; block 2 is oldest and goes
    doLookup(6'd45, 1'b1, 6'd7, "R7");
    doLookup(6'd2, 1'b0, 6'd0, "R7");
    doLookup(6'd7, 1'b0, 6'd0, "R7");

    // R8: miss with invalid displaced line keeps block 3
    doLookup(6'd46, 1'b0, 6'd0, "R8");
    doLookup(6'd3, 1'b0, 6'd0, "R8");

    // R9: junk while idle, block 4 survives
    for (int k = 0; k < 5; k++) idleJunk();
    doLookup(6'd4, 1'b0, 6'd0, "R9");
    doLookup(6'd6, 1'b0, 6'd0, "R9");

    // Random traffic through a model direct-mapped cache
    applyReset();
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a;
      int idx;
      a   = AW'($urandom % 12);
      idx = int'(a) % LINES;
      if (($urandom % 16) == 0) cV[$urandom % LINES] = 1'b0;
      if (cV[idx] && cA[idx] == a) begin
        idleJunk();
      end else begin
        bit willHit;
        willHit = 1'b0;
        for (int i = 0; i < N; i++) if (mV[i] && mA[i] == a) willHit = 1'b1;
        doLookup(a, cV[idx], cA[idx], willHit ? "R3" : "R10");
        cV[idx] = 1'b1;
        cA[idx] = a;
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule